// File: doc/BRIEF.md
# Serial Highway Command Repeat and Scan Sequencer

This block holds the command word for one transaction on a serial crate highway: a function code, a crate number, a station number and a sub-address. It launches a message, as a one-cycle strobe, when the host writes a command with a function that needs no data. When the function carries write data, it waits and launches when the host writes the data register. It keeps the transaction busy until the reply or a timeout arrives. It also holds the 24-bit reply data and shows it to the host as a low and a high 16-bit word.

Two mode bits in the command word support polling loops. In repeat mode, reading the low data word starts the same message again. In scan mode, each accepted reply moves the address on according to the returned Q bit. A Q of 1 steps the sub-address. A Q of 0 clears the sub-address and steps the station. Stepping past the last station forces the crate field to zero, so that the next message is not recognised and the loop ends. A status bit flags this case.

Top module: `hwy_cmd_seq`

## Requirements
- R1: After reset the launch strobe, busy, scan-ended flag, mode outputs, host word and all command fields are zero.
- R2: The command word packs the sub-address in bits 3:0, the station in 8:4, the function in 13:9, the crate in 16:14, scan mode in bit 17 and repeat mode in bit 18. A command write whose function has bits 4:3 other than 2'b10 (a non-write function), made while idle, raises launch for exactly the next cycle. The new fields show in that same cycle, and busy rises with the launch.
- R3: A command write whose function has bits 4:3 equal to 2'b10 (a write function) does not launch. A later data-register write while idle launches it. A data-register write while the held function is not a write function does not launch.
- R4: While busy, no command write, data write or host read launches. A command write still replaces the command fields.
- R5: Busy falls in the cycle after an accepted reply or a timeout. A reply or timeout that arrives while idle is ignored: the reply data and the address fields stay as they were.
- R6: An accepted reply latches its 24 data bits. With the high select at 0 the host word is data[15:0]. With the high select at 1 it is {8'h00, data[23:16]}.
- R7: With repeat mode set, a host read of the low word while idle launches a message with unchanged fields. A read of the high word never launches. With scan mode clear, a reply leaves the fields unchanged.
- R8: With scan mode set and the scan-ended flag clear, an accepted reply with Q=1 adds one to the sub-address, wrapping modulo 16, and leaves the station and crate unchanged.
- R9: With scan mode set, the scan-ended flag clear and Q=0, the sub-address becomes 0 and the station increments. This holds when the station is below 24.
- R10: With scan mode set, Q=0 and a station of 24 or more, the station increments, the crate becomes 0 and the scan-ended flag is set. While the flag is set, replies no longer step the address. A command write clears the flag.
- R11: When a reply and a timeout arrive in the same cycle, the reply is the one handled: its data is latched and the scan step applies.
- R12: When a command write and an accepted reply fall in the same cycle, the written fields win, and the reply data is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_word | input | 19 | Command word written by the host |
| wd_wr | input | 1 | Host write strobe for the write-data register |
| host_rd | input | 1 | Host read strobe for the reply-data register |
| host_rd_hi | input | 1 | Selects the high reply word (1) or the low reply word (0) |
| rpl_valid | input | 1 | A reply has arrived |
| rpl_q | input | 1 | Q bit of the reply |
| rpl_data | input | 24 | Data carried by the reply |
| tmo | input | 1 | No reply within the allowed time |
| launch | output | 1 | One-cycle message launch strobe |
| busy | output | 1 | A message is awaiting its reply or timeout |
| scan_end | output | 1 | The scan stepped past the last station |
| cmd_fn | output | 5 | Current function code |
| cmd_crate | output | 3 | Current crate number |
| cmd_sn | output | 5 | Current station number |
| cmd_sa | output | 4 | Current sub-address |
| mode_rep | output | 1 | Repeat mode bit |
| mode_scan | output | 1 | Scan mode bit |
| host_word | output | 16 | Selected 16-bit word of the reply data |

## Verification
Two things can land in the same clock. A reply can meet its own timeout, and a reply can meet a host command write. The bench drives each pair in one cycle while a scan is running. For the first pair it checks that the sub-address stepped and the reply data was latched. For the second it checks that the written fields win over the scan step while the data still lands. The scan sweeps start at several stations and sub-addresses and use mixed Q patterns. They check each step, the sub-address wrap and the forced crate zero against an arithmetic model kept in the bench.

// File: rtl/hwy_seq_pkg.sv
package hwy_seq_pkg;
    parameter int SA_W  = 4;
    parameter int SN_W  = 5;
    parameter int FN_W  = 5;
    parameter int CR_W  = 3;
    parameter int RD_W  = 24;
    parameter int HST_W = 16;

    typedef struct packed {
        logic            mr;
        logic            mq;
        logic [CR_W-1:0] cr;
        logic [FN_W-1:0] fn;
        logic [SN_W-1:0] sn;
        logic [SA_W-1:0] sa;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    // write-type functions: top two function bits equal 2'b10
    function automatic logic is_write_fn(input logic [FN_W-1:0] fn);
        return fn[FN_W-1 -: 2] == 2'b10;
    endfunction
endpackage

// File: rtl/hwy_addr_step.sv
module hwy_addr_step
    import hwy_seq_pkg::*;
#(
    parameter int SN_LAST = 24
) (
    input  cmd_t cur,
    input  logic q,
    output cmd_t nxt,
    output logic end_hit
);
    localparam logic [SN_W-1:0] SN_LIM = SN_W'(SN_LAST);

    always_comb begin
        nxt     = cur;
        end_hit = 1'b0;
        if (q) begin
            nxt.sa = cur.sa + SA_W'(1);
        end else begin
            nxt.sa = '0;
            nxt.sn = cur.sn + SN_W'(1);
            if (cur.sn >= SN_LIM) begin
                nxt.cr  = '0;
                end_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hwy_rd_word.sv
module hwy_rd_word
    import hwy_seq_pkg::*;
(
    input  logic [RD_W-1:0]  rdata,
    input  logic             hi_sel,
    output logic [HST_W-1:0] word
);
    logic [HST_W-1:0] hi_word;

    generate
        if (RD_W > HST_W) begin : g_split
            assign hi_word = {{(2*HST_W-RD_W){1'b0}}, rdata[RD_W-1:HST_W]};
        end else begin : g_single
            assign hi_word = '0;
        end
    endgenerate

    assign word = hi_sel ? hi_word : rdata[HST_W-1:0];
endmodule

// File: rtl/hwy_cmd_seq.sv
module hwy_cmd_seq
    import hwy_seq_pkg::*;
#(
    parameter int SN_LAST = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             wd_wr,
    input  logic             host_rd,
    input  logic             host_rd_hi,
    input  logic             rpl_valid,
    input  logic             rpl_q,
    input  logic [RD_W-1:0]  rpl_data,
    input  logic             tmo,
    output logic             launch,
    output logic             busy,
    output logic             scan_end,
    output logic [FN_W-1:0]  cmd_fn,
    output logic [CR_W-1:0]  cmd_crate,
    output logic [SN_W-1:0]  cmd_sn,
    output logic [SA_W-1:0]  cmd_sa,
    output logic             mode_rep,
    output logic             mode_scan,
    output logic [HST_W-1:0] host_word
);
    typedef struct packed {
        cmd_t            cmd;
        logic            busy;
        logic            launch;
        logic            scan_end;
        logic [RD_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;
    cmd_t cmd_in, step_nxt;
    logic step_end;
    logic reply_ok, tmo_ok, launch_req;

    assign cmd_in = cmd_t'(cmd_word);

    hwy_addr_step #(.SN_LAST(SN_LAST)) u_step (
        .cur     (s_q.cmd),
        .q       (rpl_q),
        .nxt     (step_nxt),
        .end_hit (step_end)
    );

    hwy_rd_word u_rdw (
        .rdata  (s_q.rdata),
        .hi_sel (host_rd_hi),
        .word   (host_word)
    );

    always_comb begin
        s_d        = s_q;
        s_d.launch = 1'b0;
        reply_ok   = rpl_valid && s_q.busy;
        tmo_ok     = tmo && s_q.busy && !rpl_valid;
        launch_req = !s_q.busy && (
                       (cmd_wr && !is_write_fn(cmd_in.fn)) ||
                       (wd_wr && !cmd_wr && is_write_fn(s_q.cmd.fn)) ||
                       (host_rd && !host_rd_hi && !cmd_wr && s_q.cmd.mr));

        if (reply_ok) begin
            s_d.rdata = rpl_data;
            if (s_q.cmd.mq && !s_q.scan_end) begin
                s_d.cmd = step_nxt;
                if (step_end) s_d.scan_end = 1'b1;
            end
        end
        if (reply_ok || tmo_ok) s_d.busy = 1'b0;

        if (cmd_wr) begin
            s_d.cmd      = cmd_in;
            s_d.scan_end = 1'b0;
        end
        if (launch_req) begin
            s_d.launch = 1'b1;
            s_d.busy   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign launch    = s_q.launch;
    assign busy      = s_q.busy;
    assign scan_end  = s_q.scan_end;
    assign cmd_fn    = s_q.cmd.fn;
    assign cmd_crate = s_q.cmd.cr;
    assign cmd_sn    = s_q.cmd.sn;
    assign cmd_sa    = s_q.cmd.sa;
    assign mode_rep  = s_q.cmd.mr;
    assign mode_scan = s_q.cmd.mq;
endmodule

// File: rtl/hwy_cmd_seq_chk.sv
module hwy_cmd_seq_chk
    import hwy_seq_pkg::*;
#(
    parameter int SN_LAST = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_word,
    input logic             wd_wr,
    input logic             host_rd,
    input logic             host_rd_hi,
    input logic             rpl_valid,
    input logic             rpl_q,
    input logic [RD_W-1:0]  rpl_data,
    input logic             tmo,
    input logic             launch,
    input logic             busy,
    input logic             scan_end,
    input logic [FN_W-1:0]  cmd_fn,
    input logic [CR_W-1:0]  cmd_crate,
    input logic [SN_W-1:0]  cmd_sn,
    input logic [SA_W-1:0]  cmd_sa,
    input logic             mode_rep,
    input logic             mode_scan,
    input logic [HST_W-1:0] host_word
);
    localparam logic [SN_W-1:0] SN_LIM = SN_W'(SN_LAST);

    cmd_t w;
    logic step_rpl;
    assign w        = cmd_t'(cmd_word);
    assign step_rpl = rpl_valid && busy && !cmd_wr && mode_scan && !scan_end;

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> busy);                                                   // R2
    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !$past(busy));                                           // R4
    AST_WRFN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && w.fn[FN_W-1 -: 2] == 2'b10) |=> !launch);                // R3
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (rpl_valid || tmo)) |=> !busy);                            // R5
    AST_REPEAT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && busy && !cmd_wr && !mode_scan)
        |=> $stable({cmd_crate, cmd_sn, cmd_sa}));                          // R7
    AST_SA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rpl && rpl_q) |=> (cmd_sa == $past(cmd_sa) + SA_W'(1))
                                && $stable(cmd_sn));                        // R8
    AST_SN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rpl && !rpl_q && cmd_sn < SN_LIM)
        |=> cmd_sa == '0 && cmd_sn == $past(cmd_sn) + SN_W'(1));            // R9
    AST_CRATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rpl && !rpl_q && cmd_sn >= SN_LIM)
        |=> cmd_crate == '0 && scan_end);                                   // R10
    AST_RPL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && busy && !host_rd_hi)
        |=> host_rd_hi || host_word == $past(rpl_data[HST_W-1:0]));         // R6
endmodule

bind hwy_cmd_seq hwy_cmd_seq_chk #(.SN_LAST(SN_LAST)) u_chk (.*);

// File: tb/sim_hwy_cmd_seq.sv
module sim_hwy_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 0, wd_wr = 0, host_rd = 0, host_rd_hi = 0;
    logic [18:0] cmd_word = '0;
    logic        rpl_valid = 0, rpl_q = 0, tmo = 0;
    logic [23:0] rpl_data = '0;
    logic        launch, busy, scan_end, mode_rep, mode_scan;
    logic [4:0]  cmd_fn, cmd_sn;
    logic [2:0]  cmd_crate;
    logic [3:0]  cmd_sa;
    logic [15:0] host_word;

    int n_run = 0, n_fail = 0;
    int e_sa, e_sn, e_cr;
    logic e_end;

    always #5 clk = ~clk;

    hwy_cmd_seq u0 (.*);

    function automatic logic [18:0] cw(input int mr, mq, cr, fn, sn, sa);
        return {mr[0], mq[0], cr[2:0], fn[4:0], sn[4:0], sa[3:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [18:0] w);
        cmd_word = w; cmd_wr = 1; @(negedge clk); cmd_wr = 0;
    endtask
    task automatic do_reply(input logic q, input logic [23:0] d, input logic t);
        rpl_valid = 1; rpl_q = q; rpl_data = d; tmo = t;
        @(negedge clk); rpl_valid = 0; tmo = 0;
    endtask
    task automatic do_read(input logic hi);
        host_rd = 1; host_rd_hi = hi; @(negedge clk); host_rd = 0; host_rd_hi = 0;
    endtask
    task automatic do_wd;
        wd_wr = 1; @(negedge clk); wd_wr = 0;
    endtask

    task automatic model_step(input logic q);
        if (e_end) return;
        if (q) e_sa = (e_sa + 1) % 16;
        else begin
            e_sa = 0;
            if (e_sn >= 24) begin e_cr = 0; e_end = 1; end
            e_sn = (e_sn + 1) % 32;
        end
    endtask

    task automatic chk_fields(input string req);
        chk(req, cmd_sa, e_sa);
        chk(req, cmd_sn, e_sn);
        chk(req, cmd_crate, e_cr);
        chk(req, scan_end, e_end);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {launch, busy, scan_end, mode_rep, mode_scan}, 0);
        chk("R1", {cmd_fn, cmd_crate, cmd_sn, cmd_sa}, 0);
        chk("R1", host_word, 0);

        // R2 / R3 / R6 sweep over every function code
        for (int fn = 0; fn < 32; fn++) begin
            automatic bit wrf = (fn / 8) == 2;
            do_cmd(cw(0, 0, 3, fn, 2, 5));
            chk("R2", launch, !wrf);
            chk("R2", {cmd_fn, cmd_crate, cmd_sn, cmd_sa}, {fn[4:0], 3'd3, 5'd2, 4'd5});
            if (wrf) begin
                chk("R3", busy, 0);
                do_wd();
                chk("R3", launch, 1);
            end
            chk("R2", busy, 1);
            do_reply(0, 24'h5A0000 + fn * 24'h10203, 0);
            chk("R5", busy, 0);
            host_rd_hi = 1; #1;
            chk("R6", host_word, {8'h00, 8'h5A + ((fn * 24'h10203) >> 16)});
            host_rd_hi = 0; #1;
            chk("R6", host_word, (fn * 24'h10203) & 16'hFFFF);
            if (!wrf) begin
                do_wd();
                chk("R3", launch, 0);
            end
        end

        // R4 busy blocks launches
        do_cmd(cw(1, 0, 1, 0, 3, 3));
        chk("R4", launch, 1);
        do_cmd(cw(1, 0, 6, 1, 9, 8));
        chk("R4", launch, 0);
        chk("R4", {cmd_crate, cmd_sn, cmd_sa}, {3'd6, 5'd9, 4'd8});
        do_read(0);
        chk("R4", launch, 0);
        do_wd();
        chk("R4", launch, 0);
        // R5 timeout ends wait, late reply ignored
        tmo = 1; @(negedge clk); tmo = 0;
        chk("R5", busy, 0);
        do_reply(1, 24'hFFFFFF, 0);
        chk("R5", host_word, 16'h0000 + (31 * 24'h10203 & 16'hFFFF));
        chk("R5", {cmd_sn, cmd_sa}, {5'd9, 4'd8});

        // R7 repeat mode
        do_cmd(cw(1, 0, 4, 0, 7, 9));
        do_reply(1, 24'h000111, 0);
        chk("R7", {cmd_crate, cmd_sn, cmd_sa}, {3'd4, 5'd7, 4'd9});
        do_read(0);
        chk("R7", launch, 1);
        chk("R7", {cmd_crate, cmd_sn, cmd_sa}, {3'd4, 5'd7, 4'd9});
        do_reply(0, 24'h000222, 0);
        do_read(1);
        chk("R7", launch, 0);

        // R8 / R9 / R10 scan sweeps
        for (int st = 0; st < 4; st++) begin
            automatic int sn0 = 20 + st * 2;
            automatic int sa0 = 13 + st % 3;
            e_sa = sa0; e_sn = sn0; e_cr = 5; e_end = 0;
            do_cmd(cw(1, 1, 5, 0, sn0, sa0));
            for (int i = 0; i < 14; i++) begin
                automatic logic q = ((i * 5 + st) % 3) != 0;
                do_reply(q, 24'(i), 0);
                model_step(q);
                chk(q ? "R8" : (e_end ? "R10" : "R9"), busy, 0);
                chk_fields(q ? "R8" : (e_end ? "R10" : "R9"));
                do_read(0);
                chk("R7", launch, 1);
            end
            do_reply(0, 0, 0);
        end
        do_cmd(cw(1, 1, 2, 1, 3, 0));
        chk("R10", scan_end, 0);

        // R11 reply and timeout together
        do_reply(1, 24'hABCDEF, 1);
        chk("R11", cmd_sa, 1);
        chk("R11", host_word, 16'hCDEF);
        chk("R11", busy, 0);

        // R12 command write and reply together
        do_read(0);
        chk("R12", launch, 1);
        cmd_word = cw(0, 1, 7, 2, 11, 6); cmd_wr = 1;
        rpl_valid = 1; rpl_q = 1; rpl_data = 24'h123456;
        @(negedge clk); cmd_wr = 0; rpl_valid = 0;
        chk("R12", {cmd_crate, cmd_sn, cmd_sa}, {3'd7, 5'd11, 4'd6});
        chk("R12", host_word, 16'h3456);
        chk("R12", {launch, busy}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule